// File: doc/BRIEF.md
# PHY Control Register Bank with Bit-Masked Writes

This block is a small set of 32-bit control registers on a plain single-cycle memory-mapped bus. Every write carries its own bit-enable mask in the upper sixteen bits of the write data. Only the lower-half bits whose enable bit is set take the new value, so software can flip one field without reading the register first.

The bank holds two writable registers and one read-only word. The lane power register holds one idle bit per lane. The configuration port register presents a strobe, an address and a data nibble to a PHY configuration interface. The status word returns the nibble that the PHY drives back, and bit 1 of that nibble is the PLL lock flag.

Reads are answered one cycle after the request, with a valid pulse, and never stall. Offsets that are not mapped read as zero and ignore writes.

Top module: `phy_ctrl_regbank`

## Requirements
- R1: On a write to a control register, low-half bit i takes wdata[i] when wdata[16+i] is 1 and keeps its old value when wdata[16+i] is 0.
- R2: A write whose mask bits [31:16] are all zero leaves the addressed register and its outputs unchanged.
- R3: The lane power register is at offset 0xE214. Bit n+3 is the idle control for lane n (n = 0..3) and drives lane_idle[n].
- R4: After reset the lane power register reads 0x00000078, so all four lanes are idle. The configuration port register reads 0x00000000.
- R5: The configuration port register is at offset 0xE220. Bit 0 drives cfg_strobe, bits [6:1] drive cfg_addr and bits [10:7] drive cfg_wdata.
- R6: The status word at offset 0xE2A4 returns phy_cfg_rdata in bits [11:8], sampled in the request cycle, with all other bits zero. Bit 9 is therefore the PLL lock flag.
- R7: Bits [31:16] of every read response are zero.
- R8: A read of any other offset returns zero, and a write to any other offset changes no register.
- R9: bus_rvalid is high in exactly the cycle after each cycle with bus_rd high, and bus_rdata is valid in that cycle.
- R10: Writes to the status offset have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 16 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data: [31:16] bit-enable mask, [15:0] value |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after bus_rd |
| phy_cfg_rdata | input | 4 | Configuration readback nibble from the PHY |
| lane_idle | output | 4 | Per-lane idle control |
| cfg_strobe | output | 1 | Configuration write strobe to the PHY |
| cfg_addr | output | 6 | Configuration register address to the PHY |
| cfg_wdata | output | 4 | Configuration write data to the PHY |

## Verification
The assertions assume that a request does not read and write the same offset in one cycle. They also assume that bus_rd and bus_wr are low while reset is held, because the valid-timing property compares the response with the previous cycle's request. The stimulus drives every request for exactly one cycle from the falling edge and never overlaps a read with a write. It holds phy_cfg_rdata steady across each status read, so the sampled nibble is known when the expected value is queued.

// File: rtl/phy_regbank_pkg.sv
// Package: shared widths and the read-select type for the PHY control bank.
// Assumes a 32-bit bus whose upper half is the write mask for the lower half.
package phy_regbank_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LANE = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_STAT = 2'd3
    } regsel_e;
endpackage

// File: rtl/bitmask_reg.sv
// Module: bitmask_reg
// A W-bit register in which each bit is loaded on its own enable.
// On a write, bit i takes din[i] only when mask[i] is set.
// Assumes a synchronous active-low reset that loads RST_VAL.
module bitmask_reg #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit storage: load on write when this bit's mask is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= RST_VAL[i];
            else if (wr_en && mask[i])
                q[i] <= din[i];
        end
    end
endmodule

// File: rtl/regbank_decode.sv
// Module: regbank_decode
// Maps a byte offset to one of the bank's registers, or to none.
// Assumes the three offsets are distinct.
module regbank_decode
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] LANE_OFS = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'hE2A4
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_e           sel
);
    // Offset compare: exact match selects a register
    always_comb begin
        if (addr == LANE_OFS)
            sel = SEL_LANE;
        else if (addr == CFG_OFS)
            sel = SEL_CFG;
        else if (addr == STAT_OFS)
            sel = SEL_STAT;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/regbank_rdport.sv
// Module: regbank_rdport
// Registered read port. It answers every read one cycle later with a valid
// strobe. The upper half is always zero, and unmapped offsets give zero.
// Assumes the status word is already formatted by the caller.
module regbank_rdport
    import phy_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  regsel_e           sel,
    input  logic [HALF_W-1:0] lane_q,
    input  logic [HALF_W-1:0] cfg_q,
    input  logic [HALF_W-1:0] stat_w,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [HALF_W-1:0] mux_lo;

    // Source select for the low half of the response
    always_comb begin
        unique case (sel)
            SEL_LANE: mux_lo = lane_q;
            SEL_CFG:  mux_lo = cfg_q;
            SEL_STAT: mux_lo = stat_w;
            default:  mux_lo = '0;
        endcase
    end

    // Response register: capture data and raise valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en)
                rdata <= {{(DATA_W-HALF_W){1'b0}}, mux_lo};
        end
    end
endmodule

// File: rtl/phy_ctrl_regbank.sv
// Module: phy_ctrl_regbank
// A control bank for a multi-lane PHY: a lane idle register, a configuration
// port register and a read-only status word, all behind bit-masked writes.
// Assumes single-cycle requests and no same-cycle read and write of one offset.
module phy_ctrl_regbank
    import phy_regbank_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_LANES  = 4,
    parameter int LANE_LSB   = 3,
    parameter int CFG_ADDR_W = 6,
    parameter int CFG_DATA_W = 4,
    parameter int STAT_LSB   = 8,
    parameter logic [ADDR_W-1:0] LANE_OFS = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'hE2A4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic [CFG_DATA_W-1:0] phy_cfg_rdata,
    output logic [NUM_LANES-1:0]  lane_idle,
    output logic                  cfg_strobe,
    output logic [CFG_ADDR_W-1:0] cfg_addr,
    output logic [CFG_DATA_W-1:0] cfg_wdata
);
    localparam int LANE_MSB  = LANE_LSB + NUM_LANES - 1;
    localparam int CADDR_LSB = 1;
    localparam int CADDR_MSB = CADDR_LSB + CFG_ADDR_W - 1;
    localparam int CDATA_LSB = CADDR_MSB + 1;
    localparam int CDATA_MSB = CDATA_LSB + CFG_DATA_W - 1;
    localparam logic [HALF_W-1:0] LANE_RST =
        HALF_W'(((1 << NUM_LANES) - 1) << LANE_LSB);

    regsel_e           sel;
    logic [HALF_W-1:0] lane_q;
    logic [HALF_W-1:0] cfg_q;
    logic [HALF_W-1:0] stat_w;
    logic [HALF_W-1:0] wr_mask;
    logic [HALF_W-1:0] wr_val;

    assign wr_mask = bus_wdata[DATA_W-1:HALF_W];
    assign wr_val  = bus_wdata[HALF_W-1:0];

    regbank_decode #(
        .ADDR_W  (ADDR_W),
        .LANE_OFS(LANE_OFS),
        .CFG_OFS (CFG_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    bitmask_reg #(.W(HALF_W), .RST_VAL(LANE_RST)) u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bus_wr && (sel == SEL_LANE)),
        .din  (wr_val),
        .mask (wr_mask),
        .q    (lane_q)
    );

    bitmask_reg #(.W(HALF_W), .RST_VAL('0)) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bus_wr && (sel == SEL_CFG)),
        .din  (wr_val),
        .mask (wr_mask),
        .q    (cfg_q)
    );

    // Status formatting: PHY readback nibble placed at its field
    always_comb begin
        stat_w = HALF_W'(phy_cfg_rdata) << STAT_LSB;
    end

    regbank_rdport u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (bus_rd),
        .sel   (sel),
        .lane_q(lane_q),
        .cfg_q (cfg_q),
        .stat_w(stat_w),
        .rdata (bus_rdata),
        .rvalid(bus_rvalid)
    );

    // Field breakout: drive PHY-side controls from stored bits
    always_comb begin
        lane_idle  = lane_q[LANE_MSB:LANE_LSB];
        cfg_strobe = cfg_q[0];
        cfg_addr   = cfg_q[CADDR_MSB:CADDR_LSB];
        cfg_wdata  = cfg_q[CDATA_MSB:CDATA_LSB];
    end
endmodule

// File: rtl/phy_ctrl_regbank_chk.sv
// Module: phy_ctrl_regbank_chk
// Assertion checker bound to phy_ctrl_regbank. It observes only the ports.
// Assumes bus_rd and bus_wr stay low while reset is held.
module phy_ctrl_regbank_chk #(
    parameter int ADDR_W     = 16,
    parameter int NUM_LANES  = 4,
    parameter int CFG_ADDR_W = 6,
    parameter int CFG_DATA_W = 4,
    parameter logic [ADDR_W-1:0] LANE_OFS = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'hE2A4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic                  bus_rvalid,
    input logic [CFG_DATA_W-1:0] phy_cfg_rdata,
    input logic [NUM_LANES-1:0]  lane_idle,
    input logic                  cfg_strobe,
    input logic [CFG_ADDR_W-1:0] cfg_addr,
    input logic [CFG_DATA_W-1:0] cfg_wdata
);
    logic unmapped;
    assign unmapped = (bus_addr != LANE_OFS) && (bus_addr != CFG_OFS) &&
                      (bus_addr != STAT_OFS);

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[31:16] == 16'h0));

    // R9
    rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid == $past(bus_rd));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == 32'h0));

    // R2
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LANE_OFS && bus_wdata[31:16] == 16'h0)
        |=> $stable(lane_idle));

    // R1
    strobe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CFG_OFS && !bus_wdata[16]) |=> $stable(cfg_strobe));

    // R10
    stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT_OFS) |=>
        ($stable(lane_idle) && $stable(cfg_strobe) && $stable(cfg_addr) &&
         $stable(cfg_wdata)));

    // R4
    reset_value_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> ((&lane_idle) && !cfg_strobe && cfg_addr == '0 &&
                          cfg_wdata == '0));
endmodule

bind phy_ctrl_regbank phy_ctrl_regbank_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_LANES (NUM_LANES),
    .CFG_ADDR_W(CFG_ADDR_W),
    .CFG_DATA_W(CFG_DATA_W),
    .LANE_OFS  (LANE_OFS),
    .CFG_OFS   (CFG_OFS),
    .STAT_OFS  (STAT_OFS)
) u_chk (.*);

// File: tb/sim_phy_ctrl_regbank.sv
// Bench: scoreboard of expected read responses, plus output checks after writes.
module sim_phy_ctrl_regbank;
    localparam logic [15:0] OFS_LANE = 16'hE214;
    localparam logic [15:0] OFS_CFG  = 16'hE220;
    localparam logic [15:0] OFS_STAT = 16'hE2A4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [3:0]  phy_cfg_rdata = '0;
    logic [3:0]  lane_idle;
    logic        cfg_strobe;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] lane_m = 16'h0078;
    logic [15:0] cfg_m  = 16'h0000;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    phy_ctrl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .phy_cfg_rdata(phy_cfg_rdata),
        .lane_idle(lane_idle), .cfg_strobe(cfg_strobe), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata)
    );

    function automatic logic [15:0] apply_mask(logic [15:0] old, logic [31:0] w);
        return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare PHY-side outputs with the bench model (called at a falling edge)
    task automatic check_outputs(string req);
        check({req, " lane_idle"}, 32'(lane_idle), 32'(lane_m[6:3]));
        check({req, " cfg_strobe"}, 32'(cfg_strobe), 32'(cfg_m[0]));
        check({req, " cfg_addr"}, 32'(cfg_addr), 32'(cfg_m[6:1]));
        check({req, " cfg_wdata"}, 32'(cfg_wdata), 32'(cfg_m[10:7]));
    endtask

    // Driver: one-cycle write, model update, output check after the edge
    task automatic do_write(logic [15:0] a, logic [31:0] w, string req);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        if (a == OFS_LANE) lane_m = apply_mask(lane_m, w);
        else if (a == OFS_CFG) cfg_m = apply_mask(cfg_m, w);
        @(negedge clk);
        bus_wr = 1'b0;
        check_outputs(req);
    endtask

    // Driver: one-cycle read, pushes the expected response
    task automatic do_read(logic [15:0] a, string req);
        logic [31:0] e;
        if (a == OFS_LANE) e = {16'h0, lane_m};
        else if (a == OFS_CFG) e = {16'h0, cfg_m};
        else if (a == OFS_STAT) e = {20'h0, phy_cfg_rdata, 8'h00};
        else e = 32'h0;
        exp_q.push_back(e);
        tag_q.push_back(req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: pop and compare each response when it appears
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected response: actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R4 reset");
        do_read(OFS_LANE, "R4 lane reset read");
        do_read(OFS_CFG, "R4 cfg reset read");
        phy_cfg_rdata = 4'hA;
        do_read(OFS_STAT, "R6 status A");
        // R3: wake lane 0 only (mask bit 19)
        do_write(OFS_LANE, 32'h0008_0000, "R3 lane0 wake");
        check("R3 lane_idle value", 32'(lane_idle), 32'h0000000E);
        do_read(OFS_LANE, "R3 lane read");
        // R2: zero mask, all-ones data
        do_write(OFS_LANE, 32'h0000_FFFF, "R2 zero mask");
        do_read(OFS_LANE, "R2 lane read");
        // R1: full field mask, lanes 1 and 3 idle
        do_write(OFS_LANE, 32'h0078_0050, "R1 lane field");
        check("R1 lane_idle value", 32'(lane_idle), 32'h0000000A);
        // R5: set address 0x10 and data 0x8, strobe low
        do_write(OFS_CFG, 32'h07FF_0420, "R5 cfg setup");
        check("R5 cfg_addr value", 32'(cfg_addr), 32'h10);
        do_write(OFS_CFG, 32'h0001_0001, "R5 strobe high");
        check("R5 strobe value", 32'(cfg_strobe), 32'h1);
        do_read(OFS_CFG, "R5 cfg read");
        do_write(OFS_CFG, 32'h0001_0000, "R1 strobe low");
        // R7: all bits written, response upper half still zero
        do_write(OFS_CFG, 32'hFFFF_FFFF, "R7 cfg full");
        do_read(OFS_CFG, "R7 cfg read");
        // R6: lock flag at bit 9
        phy_cfg_rdata = 4'h2;
        do_read(OFS_STAT, "R6 lock bit9");
        phy_cfg_rdata = 4'h0;
        do_read(OFS_STAT, "R6 status zero");
        // R10: status offset ignores writes
        do_write(OFS_STAT, 32'hFFFF_FFFF, "R10 status write");
        do_read(OFS_STAT, "R10 status read");
        do_read(OFS_LANE, "R10 lane read");
        // R8: unmapped offsets
        do_write(16'hE218, 32'hFFFF_0000, "R8 unmapped write");
        do_read(16'h0000, "R8 unmapped 0000");
        do_read(16'hE218, "R8 unmapped E218");
        do_read(OFS_CFG, "R8 cfg after unmapped");
        // R9: back-to-back reads, one response each
        do_read(OFS_LANE, "R9 b2b 1");
        do_read(OFS_CFG, "R9 b2b 2");
        do_read(16'h1234, "R9 b2b 3");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule